// File: doc/BRIEF.md
# Dual-Mode Serial Transmitter

This block turns parallel characters from a host into a serial bit stream. It can frame that stream in two ways. The host writes one character of 5 to 8 bits at a time into a holding buffer. Whenever the output shift register runs dry at a bit boundary, the buffer contents move into it without any host action. This means one character can be in flight while the next one waits.

Bit timing comes from a transmit bit-enable input. It is independent of any receive-side timing, so the baud rate of this direction is set only by how often that enable pulses. All mode settings are static inputs.

- **Asynchronous mode:** each character is wrapped in a start bit, an optional parity bit and one or two stop bits.
- **Synchronous mode:** one or two programmable sync characters go out ahead of the data. The same sync sequence is repeated as fill whenever no data character is waiting at a character boundary.

Top module: `dual_serial_tx`

## Requirements
- R1: The character length is 5 + `len_code` bits (`len_code` 0..3 gives 5, 6, 7 or 8 bits). Only the low bits of `wr_data` are sent, least significant bit first, in both modes.
- R2: In asynchronous mode (`sync_mode`=0) each character starts with a start bit of 0. The line rests at 1 when nothing is being sent.
- R3: `par_mode` 2'b01 appends even parity and 2'b10 appends odd parity, computed over the sent data bits only. 2'b00 and 2'b11 append no parity bit. The parity bit follows the last data bit in both modes.
- R4: In asynchronous mode the frame ends with one stop bit of 1, or two when `two_stop`=1.
- R5: `txd` changes only on a clock edge where `bit_en` is high, and each transmitted bit lasts exactly one `bit_en` period.
- R6: A write taken while `buf_ready` is high fills the holding buffer and drives `buf_ready` low. At the first bit boundary with the buffer full, the character moves into the shift register and `buf_ready` returns high. Back-to-back characters leave no idle bit between them.
- R7: A write while `buf_ready` is low is ignored. Neither the buffered character nor the one in flight is altered.
- R8: `tx_empty` is high only when the holding buffer is empty and no data character is being shifted out.
- R9: In synchronous mode, a character written to an idle line is preceded by `sync_a` (`two_sync`=0) or by `sync_a` then `sync_b` (`two_sync`=1). Each sync character is sent at the character length without parity. Data characters get no start or stop bits.
- R10: In synchronous mode, once a stream has started, a character boundary with the buffer empty sends the sync sequence again as fill. `tx_empty` stays high during fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Transmit bit-time enable, one pulse per bit |
| sync_mode | input | 1 | 0 = asynchronous framing, 1 = synchronous framing |
| len_code | input | 2 | Character length code, length = 5 + code |
| par_mode | input | 2 | 00 none, 01 even, 10 odd, 11 none |
| two_stop | input | 1 | Asynchronous: send two stop bits |
| two_sync | input | 1 | Synchronous: send two sync characters |
| sync_a | input | 8 | First sync character |
| sync_b | input | 8 | Second sync character |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host character |
| txd | output | 1 | Serial data out |
| buf_ready | output | 1 | Holding buffer can take a write |
| tx_empty | output | 1 | Buffer and shift register hold no data |

## Verification
Asynchronous frames are sent at all four character lengths with every parity choice and both stop counts. The data patterns are all-zeros, all-ones and alternating bits, so that bit order, parity sense and frame length each show up as a distinct bit error.

A burst of back-to-back writes separates correct automatic reload from a design that drops or delays the buffered character. A second write placed in the same bit period as the first shows whether a full buffer really rejects it.

Synchronous runs use one and two sync characters with different lengths. Writing the second character in the middle of a fill sequence shows whether fill completes its sync pair before the data goes out.

// File: rtl/dstx_pkg.sv
package dstx_pkg;

    localparam int CHAR_MAX = 8;
    localparam int MIN_CHAR = 5;
    localparam int FRAME_W  = CHAR_MAX + 4;
    localparam int CNT_W    = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_OFF  = 2'b11
    } par_e;

    typedef enum logic [1:0] {
        SRC_IDLE,
        SRC_DATA,
        SRC_SYNC_A,
        SRC_SYNC_B
    } src_e;

    typedef struct packed {
        logic       sync_mode;
        logic [1:0] len_code;
        par_e       par;
        logic       two_stop;
        logic       two_sync;
    } cfg_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [CNT_W-1:0]   count;
    } frame_t;

    function automatic int char_bits(logic [1:0] code);
        return MIN_CHAR + int'(code);
    endfunction

    function automatic logic par_enabled(par_e p);
        return (p == PAR_EVEN) || (p == PAR_ODD);
    endfunction

    // Lay out a frame LSB first; unused upper bits stay at the idle level.
    function automatic frame_t build_frame(logic [CHAR_MAX-1:0] ch, cfg_t c,
                                           logic add_par, logic par_bit, logic wrap);
        frame_t f;
        int     pos;
        int     n;
        n      = char_bits(c.len_code);
        f.bits = '1;
        pos    = 0;
        if (wrap) begin
            f.bits[0] = 1'b0;
            pos = 1;
        end
        for (int i = 0; i < CHAR_MAX; i++) begin
            if (i < n) f.bits[pos + i] = ch[i];
        end
        pos = pos + n;
        if (add_par && par_enabled(c.par)) begin
            f.bits[pos] = par_bit;
            pos = pos + 1;
        end
        if (wrap) pos = pos + (c.two_stop ? 2 : 1);
        f.count = CNT_W'(pos);
        return f;
    endfunction

endpackage

// File: rtl/dstx_hold_buf.sv
module dstx_hold_buf
    import dstx_pkg::*;
#(
    parameter int W = CHAR_MAX
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic         valid,
    output logic [W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            if (take) valid <= 1'b0;
            if (wr_en && !valid) begin
                valid <= 1'b1;
                data  <= wr_data;
            end
        end
    end

    // R7: a write into a full buffer leaves the held character alone
    p_full_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && valid && !take) |=> (valid && $stable(data)));

endmodule

// File: rtl/dstx_parity.sv
module dstx_parity
    import dstx_pkg::*;
#(
    parameter int W = CHAR_MAX
) (
    input  logic [W-1:0] data,
    input  logic [1:0]   len_code,
    input  par_e         par,
    output logic         par_bit
);

    logic [W-1:0] mask;
    logic         raw;

    for (genvar i = 0; i < W; i++) begin : g_mask
        assign mask[i] = (i < char_bits(len_code));
    end

    assign raw     = ^(data & mask);
    assign par_bit = (par == PAR_ODD) ? ~raw : raw;

endmodule

// File: rtl/dstx_seq.sv
module dstx_seq
    import dstx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic busy,
    input  logic last_bit,
    input  logic buf_valid,
    input  cfg_t cfg,
    output src_e src,
    output logic load,
    output logic take,
    output logic in_stream
);

    logic boundary;
    logic b_pend;

    assign boundary = bit_en && (!busy || last_bit);

    always_comb begin
        src = SRC_IDLE;
        if (boundary) begin
            if (cfg.sync_mode && b_pend) begin
                src = SRC_SYNC_B;
            end else if (buf_valid) begin
                src = (cfg.sync_mode && !in_stream) ? SRC_SYNC_A : SRC_DATA;
            end else if (cfg.sync_mode && in_stream) begin
                src = SRC_SYNC_A;
            end
        end
    end

    assign load = (src != SRC_IDLE);
    assign take = (src == SRC_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            b_pend    <= 1'b0;
            in_stream <= 1'b0;
        end else if (boundary) begin
            b_pend    <= (src == SRC_SYNC_A) && cfg.two_sync;
            in_stream <= cfg.sync_mode && load;
        end
    end

    // R9: a second sync character is only owed inside a running stream
    p_pend_in_stream_r9: assert property (@(posedge clk) disable iff (rst)
        b_pend |-> in_stream);

endmodule

// File: rtl/dstx_shift.sv
module dstx_shift
    import dstx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bit_en,
    input  logic   load,
    input  frame_t frame,
    input  logic   is_data_in,
    output logic   txd,
    output logic   busy,
    output logic   last_bit,
    output logic   is_data
);

    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   rem;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '1;
            rem     <= '0;
            busy    <= 1'b0;
            is_data <= 1'b0;
        end else if (bit_en) begin
            if (load) begin
                shreg   <= frame.bits;
                rem     <= frame.count;
                busy    <= 1'b1;
                is_data <= is_data_in;
            end else if (busy) begin
                if (rem > CNT_W'(1)) begin
                    shreg <= {1'b1, shreg[FRAME_W-1:1]};
                    rem   <= rem - CNT_W'(1);
                end else begin
                    busy    <= 1'b0;
                    is_data <= 1'b0;
                end
            end
        end
    end

    assign txd      = busy ? shreg[0] : 1'b1;
    assign last_bit = busy && (rem == CNT_W'(1));

    // R5: the line only moves on a bit-enable edge
    p_bit_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(txd));

    // R1: a running frame always has bits left
    p_busy_count_r1: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rem != '0));

endmodule

// File: rtl/dual_serial_tx.sv
module dual_serial_tx
    import dstx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_en,
    input  logic                sync_mode,
    input  logic [1:0]          len_code,
    input  logic [1:0]          par_mode,
    input  logic                two_stop,
    input  logic                two_sync,
    input  logic [CHAR_MAX-1:0] sync_a,
    input  logic [CHAR_MAX-1:0] sync_b,
    input  logic                wr_en,
    input  logic [CHAR_MAX-1:0] wr_data,
    output logic                txd,
    output logic                buf_ready,
    output logic                tx_empty
);

    cfg_t                cfg;
    logic                buf_valid;
    logic [CHAR_MAX-1:0] buf_data;
    logic                take;
    logic                load;
    logic                in_stream;
    src_e                src;
    logic                par_bit;
    frame_t              frame;
    logic                busy;
    logic                last_bit;
    logic                is_data;

    assign cfg = '{sync_mode: sync_mode, len_code: len_code, par: par_e'(par_mode),
                   two_stop: two_stop, two_sync: two_sync};

    dstx_hold_buf #(.W(CHAR_MAX)) u_buf (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .take(take), .valid(buf_valid), .data(buf_data)
    );

    dstx_parity #(.W(CHAR_MAX)) u_par (
        .data(buf_data), .len_code(len_code), .par(cfg.par), .par_bit(par_bit)
    );

    dstx_seq u_seq (
        .clk(clk), .rst(rst), .bit_en(bit_en), .busy(busy), .last_bit(last_bit),
        .buf_valid(buf_valid), .cfg(cfg), .src(src), .load(load), .take(take),
        .in_stream(in_stream)
    );

    always_comb begin
        unique case (src)
            SRC_DATA:   frame = build_frame(buf_data, cfg, 1'b1, par_bit, !cfg.sync_mode);
            SRC_SYNC_A: frame = build_frame(sync_a, cfg, 1'b0, 1'b0, 1'b0);
            SRC_SYNC_B: frame = build_frame(sync_b, cfg, 1'b0, 1'b0, 1'b0);
            default:    frame = '0;
        endcase
    end

    dstx_shift u_shift (
        .clk(clk), .rst(rst), .bit_en(bit_en), .load(load), .frame(frame),
        .is_data_in(take), .txd(txd), .busy(busy), .last_bit(last_bit),
        .is_data(is_data)
    );

    assign buf_ready = !buf_valid;
    assign tx_empty  = !buf_valid && !is_data;

    // R6: moving a character out frees the buffer on the next cycle
    p_take_frees_r6: assert property (@(posedge clk) disable iff (rst)
        take |=> buf_ready);

    // R2: an asynchronous data frame opens with a low start bit
    p_async_start_r2: assert property (@(posedge clk) disable iff (rst)
        (take && !sync_mode) |=> !txd);

    // R10: a synchronous stream with nothing queued keeps sending fill
    p_fill_r10: assert property (@(posedge clk) disable iff (rst)
        (bit_en && last_bit && !buf_valid && sync_mode && in_stream) |=> busy);

endmodule

// File: tb/sim_dual_serial_tx.sv
`timescale 1ns/1ps
module sim_dual_serial_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic [1:0] phase = 2'd0;
    logic       bit_run = 1'b1;
    logic       sync_mode = 1'b0;
    logic [1:0] len_code = 2'd3;
    logic [1:0] par_mode = 2'd0;
    logic       two_stop = 1'b0;
    logic       two_sync = 1'b0;
    logic [7:0] sync_a = 8'h00;
    logic [7:0] sync_b = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, buf_ready, tx_empty;

    int    n_tests = 0;
    int    n_fail = 0;
    int    stable_err = 0;
    bit    chk_idle = 1'b1;
    bit    q_bit[$];
    string q_tag[$];
    logic  be, last_txd, have_last = 1'b0;
    bit    exp_b;
    string exp_t;

    always #5 clk = ~clk;

    dual_serial_tx u0 (
        .clk(clk), .rst(rst), .bit_en(bit_en), .sync_mode(sync_mode),
        .len_code(len_code), .par_mode(par_mode), .two_stop(two_stop),
        .two_sync(two_sync), .sync_a(sync_a), .sync_b(sync_b),
        .wr_en(wr_en), .wr_data(wr_data), .txd(txd), .buf_ready(buf_ready),
        .tx_empty(tx_empty)
    );

    // bit-enable: one pulse every four clocks
    always @(negedge clk) begin
        phase  <= phase + 2'd1;
        bit_en <= bit_run && (phase == 2'd3);
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(bit b, string tag);
        q_bit.push_back(b);
        q_tag.push_back(tag);
    endtask

    function automatic bit exp_par(logic [7:0] d, int n, int par);
        bit p = 1'b0;
        for (int i = 0; i < n; i++) p ^= d[i];
        return (par == 2) ? ~p : p;
    endfunction

    task automatic push_async(logic [7:0] d, int n, int par, bit stops2);
        push(1'b0, "R2");
        for (int i = 0; i < n; i++) push(d[i], "R1");
        if (par == 1 || par == 2) push(exp_par(d, n, par), "R3");
        push(1'b1, "R4");
        if (stops2) push(1'b1, "R4");
    endtask

    task automatic push_char(logic [7:0] d, int n, string tag);
        for (int i = 0; i < n; i++) push(d[i], tag);
    endtask

    task automatic push_sync_data(logic [7:0] d, int n, int par);
        push_char(d, n, "R9");
        if (par == 1 || par == 2) push(exp_par(d, n, par), "R3");
    endtask

    task automatic wr(logic [7:0] d);
        @(negedge clk);
        while (!buf_ready) @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk(buf_ready == 1'b0, "R6", "buf_ready after write", int'(buf_ready), 0);
    endtask

    task automatic drain();
        while (q_bit.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic async_char(logic [7:0] d, int lc, int par, bit s2);
        @(negedge clk);
        len_code = 2'(lc); par_mode = 2'(par); two_stop = s2;
        wr(d);
        push_async(d, 5 + lc, par, s2);
        drain();
        chk(tx_empty == 1'b1, "R8", "tx_empty after frame", int'(tx_empty), 1);
    endtask

    // monitor: pops expected bits at each bit-enable edge
    initial begin
        forever begin
            @(posedge clk);
            be = bit_en;
            #1;
            if (rst) begin
                have_last = 1'b0;
            end else if (be) begin
                if (q_bit.size() > 0) begin
                    exp_b = q_bit.pop_front();
                    exp_t = q_tag.pop_front();
                    chk(txd === exp_b, exp_t, "serial bit", int'(txd), int'(exp_b));
                end else if (chk_idle) begin
                    chk(txd === 1'b1, "R2", "idle line", int'(txd), 1);
                end
                last_txd  = txd;
                have_last = 1'b1;
            end else if (have_last && txd !== last_txd) begin
                stable_err++;
            end
        end
    end

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R2", "reset txd", int'(txd), 1);
        chk(buf_ready == 1'b1, "R6", "reset buf_ready", int'(buf_ready), 1);
        chk(tx_empty == 1'b1, "R8", "reset tx_empty", int'(tx_empty), 1);
        repeat (8) @(negedge clk);

        // R1..R4: lengths, parity, stop bits
        async_char(8'hA5, 3, 0, 1'b0);
        async_char(8'h13, 0, 1, 1'b1);
        async_char(8'hFF, 1, 2, 1'b0);
        async_char(8'h00, 2, 1, 1'b1);
        async_char(8'h3C, 3, 2, 1'b1);
        async_char(8'h55, 2, 3, 1'b0);
        async_char(8'hE6, 1, 1, 1'b0);

        // R6 back-to-back: three characters with no gap
        @(negedge clk);
        len_code = 2'd3; par_mode = 2'd1; two_stop = 1'b0;
        wr(8'h81); push_async(8'h81, 8, 1, 1'b0);
        wr(8'h7E); push_async(8'h7E, 8, 1, 1'b0);
        wr(8'hC9); push_async(8'hC9, 8, 1, 1'b0);
        @(negedge clk);
        while (!buf_ready) @(negedge clk);
        chk(tx_empty == 1'b0, "R8", "tx_empty while data shifts", int'(tx_empty), 0);
        drain();
        chk(tx_empty == 1'b1, "R8", "tx_empty after burst", int'(tx_empty), 1);

        // R7: second write inside the same bit period is rejected
        @(negedge clk);
        len_code = 2'd3; par_mode = 2'd0; two_stop = 1'b0;
        while (phase != 2'd0) @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h96;
        @(negedge clk);
        chk(buf_ready == 1'b0, "R7", "buffer full before second write", int'(buf_ready), 0);
        wr_data = 8'h0F;
        @(negedge clk);
        wr_en = 1'b0;
        push_async(8'h96, 8, 0, 1'b0);
        drain();
        chk(buf_ready == 1'b1, "R7", "rejected write did not land", int'(buf_ready), 1);
        chk(tx_empty == 1'b1, "R7", "no extra frame after reject", int'(tx_empty), 1);

        // R9/R10: two sync characters, fill, data written during fill
        chk_idle = 1'b0;
        @(negedge clk);
        sync_mode = 1'b1; len_code = 2'd3; par_mode = 2'd0;
        two_sync = 1'b1; sync_a = 8'h16; sync_b = 8'h69;
        wr(8'hC3);
        push_char(8'h16, 8, "R9"); push_char(8'h69, 8, "R9");
        push_sync_data(8'hC3, 8, 0);
        push_char(8'h16, 8, "R10"); push_char(8'h69, 8, "R10");
        while (q_bit.size() > 12) @(negedge clk);
        chk(tx_empty == 1'b1, "R10", "tx_empty during fill", int'(tx_empty), 1);
        wr(8'h5A);
        push_sync_data(8'h5A, 8, 0);
        while (q_bit.size() != 0) @(negedge clk);
        sync_mode = 1'b0;
        repeat (12) @(negedge clk);
        chk_idle = 1'b1;
        chk(txd == 1'b1, "R2", "idle after sync stream", int'(txd), 1);
        chk(tx_empty == 1'b1, "R8", "tx_empty after sync stream", int'(tx_empty), 1);

        // R9: single sync character, 6-bit characters, even parity on data
        chk_idle = 1'b0;
        @(negedge clk);
        sync_mode = 1'b1; len_code = 2'd1; par_mode = 2'd1;
        two_sync = 1'b0; sync_a = 8'h2D;
        wr(8'h2B);
        push_char(8'h2D, 6, "R9");
        push_sync_data(8'h2B, 6, 1);
        while (q_bit.size() != 0) @(negedge clk);
        sync_mode = 1'b0;
        repeat (12) @(negedge clk);
        chk_idle = 1'b1;
        repeat (8) @(negedge clk);

        chk(stable_err == 0, "R5", "txd moves between bit enables", stable_err, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule